// File: doc/BRIEF.md
# Shift and Rotate-Through-Carry Unit

This block computes the integer shift and rotate results of an execution pipeline for operands of 1, 2, 4 or 8 bytes held in 64-bit registers. It offers seven operations: logical left shift, logical right shift, arithmetic right shift, plain rotate left and right, and rotate left and right through the carry flag. Each request carries the source value, a 6-bit count, the present carry flag and the old contents of the destination register.

The result is written back over the low operand-size bytes of the old destination, and the bytes above are left as they were. A carry flag comes out with it. The unit has one register stage. A request presented with `in_valid` high appears on `result`/`cf_out` with `out_valid` high one clock later. The outputs hold their value while no request arrives.

Top module: `shrot_unit`

## Requirements
- R1: `out_valid` is high exactly one cycle after `in_valid` was high. `result` and `cf_out` change only in the cycle after a request and hold otherwise. After reset, `out_valid`, `result` and `cf_out` are all zero.
- R2: `size` encodes 0=1 byte, 1=2 bytes, 2=4 bytes, 3=8 bytes (operand width W = 8, 16, 32, 64). The effective count n is `cnt[5:0]` when size is 3 and `cnt[4:0]` otherwise. Count bit 5 has no effect for sizes 0 to 2.
- R3: With `op`=0 (left shift), zeros enter from the bottom. `cf_out` is the last bit shifted out of bit W-1, which is zero when n > W.
- R4: With `op`=1 (logical right shift), zeros fill the vacated upper bits of the W-bit operand. `cf_out` is the last bit shifted out of bit 0, which is zero when n > W.
- R5: With `op`=2 (arithmetic right shift), vacated bits take bit W-1 of the source, not bit 63. When n > W, `cf_out` equals that sign bit.
- R6: With `op`=3 (rotate left) and `op`=4 (rotate right), the operand rotates by n modulo W. `cf_out` is result bit 0 for the left rotate and result bit W-1 for the right rotate.
- R7: With `op`=5 (rotate left through carry), the old carry lands at bit n-1, the source bits from the top of the operand fill the positions below it, and `cf_out` is source bit W-n.
- R8: With `op`=6 (rotate right through carry), the old carry lands at bit W-n, the source bits above it shift down, the bits rotated off the bottom re-enter above the carry, and `cf_out` is source bit n-1.
- R9: The through-carry rotates reduce n modulo W+1. A count that is a nonzero multiple of W+1 returns the source and the incoming carry unchanged.
- R10: For any rotate (`op` 3 to 6) with n = 0, `result` equals the old destination in full and `cf_out` equals `cf_in`.
- R11: For any shift (`op` 0 to 2) with n = 0, the low W bits of `result` take the source and `cf_out` equals `cf_in`.
- R12: Bits of `result` above W always equal the same bits of `dst_old`.
- R13: `op`=7 is reserved. It returns `dst_old` unchanged and passes `cf_in` to `cf_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| op | input | 3 | Operation code (see R3 to R8, R13) |
| size | input | 2 | Operand size code (see R2) |
| src | input | 64 | Value to be shifted or rotated |
| cnt | input | 6 | Shift or rotate count before masking |
| cf_in | input | 1 | Carry flag before the operation |
| dst_old | input | 64 | Old destination register contents |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| result | output | 64 | Merged destination value |
| cf_out | output | 1 | Carry flag after the operation |

## Verification
Every count from 0 to 63 is applied at every size and every operation. This exposes three kinds of error:
- A design that ignored the count mask would shift a narrow operand by 32 or more.
- A design that signed from bit 63 would fill a 16-bit arithmetic shift with the wrong bit.
- A design that mishandled counts above W in a through-carry rotate would lose the carry bit from the W+1 ring.

Counts of zero and nonzero multiples of W+1 are aimed at two bugs: a rotate that overwrites the destination when it should leave it alone, and a design that loses the incoming carry. Random upper destination bits show any merge that clobbers bytes above the operand. A hold window with changing inputs shows outputs that move without a request.

// File: rtl/shrot_pkg.sv
package shrot_pkg;
  localparam int XLEN  = 64;
  localparam int NSIZE = 4;
  localparam int CNTW  = 6;
  localparam int SZW   = $clog2(NSIZE);

  typedef enum logic [2:0] {
    OP_SHL = 3'd0,
    OP_SHR = 3'd1,
    OP_SAR = 3'd2,
    OP_ROL = 3'd3,
    OP_ROR = 3'd4,
    OP_RCL = 3'd5,
    OP_RCR = 3'd6,
    OP_RSV = 3'd7
  } shop_e;

  // operand width in bits for a size code
  function automatic int op_width(logic [SZW-1:0] sz);
    return 8 << sz;
  endfunction

  // ones over the low operand-size bits
  function automatic logic [XLEN-1:0] lane_mask(logic [SZW-1:0] sz);
    return {XLEN{1'b1}} >> (XLEN - op_width(sz));
  endfunction

  // count as seen by the operation: 6 bits at full width, 5 otherwise
  function automatic logic [CNTW-1:0] mask_count(logic [SZW-1:0] sz, logic [CNTW-1:0] c);
    return (sz == SZW'(NSIZE - 1)) ? c : {1'b0, c[CNTW-2:0]};
  endfunction

  function automatic logic is_rotate(shop_e op);
    return (op == OP_ROL) || (op == OP_ROR) || (op == OP_RCL) || (op == OP_RCR);
  endfunction
endpackage

// File: rtl/shrot_count.sv
module shrot_count
  import shrot_pkg::*;
(
  input  logic [SZW-1:0]  size,
  input  logic [CNTW-1:0] cnt,
  output logic [CNTW-1:0] amt,
  output logic            amt_zero
);
  always_comb begin
    amt      = mask_count(size, cnt);
    amt_zero = (amt == '0);
  end
endmodule

// File: rtl/shrot_lane.sv
module shrot_lane
  import shrot_pkg::*;
#(
  parameter int W = 8
) (
  input  shop_e           op,
  input  logic [CNTW-1:0] amt,
  input  logic [W-1:0]    src,
  input  logic            cf_in,
  output logic [W-1:0]    res,
  output logic            cf_out
);
  localparam int LW   = $clog2(W);
  localparam int RING = W + 1;

  logic [W:0]       shl_t, shr_t, sar_t;
  logic [LW-1:0]    rot_n;
  logic [2*W-1:0]   rol_t, ror_t;
  logic [6:0]       ring_n;
  logic [W:0]       rcl_ring, rcr_ring;
  logic [2*W+1:0]   rcl_t, rcr_t;

  always_comb begin
    // plain shifts carry one extra bit to catch the bit shifted out
    shl_t = {1'b0, src} << amt;
    shr_t = {src, 1'b0} >> amt;
    sar_t = $signed({src, 1'b0}) >>> amt;

    // plain rotates: count modulo W
    rot_n = amt[LW-1:0];
    rol_t = {src, src} << rot_n;
    ror_t = {src, src} >> rot_n;

    // through-carry rotates: ring of W+1 bits, count modulo W+1
    ring_n   = 7'({1'b0, amt} % 7'(RING));
    rcl_ring = {cf_in, src};
    rcr_ring = {src, cf_in};
    rcl_t    = {rcl_ring, rcl_ring} << ring_n;
    rcr_t    = {rcr_ring, rcr_ring} >> ring_n;

    res    = src;
    cf_out = cf_in;
    case (op)
      OP_SHL: begin res = shl_t[W-1:0];       cf_out = shl_t[W];        end
      OP_SHR: begin res = shr_t[W:1];         cf_out = shr_t[0];        end
      OP_SAR: begin res = sar_t[W:1];         cf_out = sar_t[0];        end
      OP_ROL: begin res = rol_t[2*W-1:W];     cf_out = rol_t[W];        end
      OP_ROR: begin res = ror_t[W-1:0];       cf_out = ror_t[W-1];      end
      OP_RCL: begin res = rcl_t[2*W:W+1];     cf_out = rcl_t[2*W+1];    end
      OP_RCR: begin res = rcr_t[W:1];         cf_out = rcr_t[0];        end
      default: begin res = src;               cf_out = cf_in;           end
    endcase
  end
endmodule

// File: rtl/shrot_merge.sv
module shrot_merge
  import shrot_pkg::*;
(
  input  shop_e                      op,
  input  logic [SZW-1:0]             size,
  input  logic                       amt_zero,
  input  logic [NSIZE-1:0][XLEN-1:0] lane_res,
  input  logic [NSIZE-1:0]           lane_cf,
  input  logic [XLEN-1:0]            dst_old,
  input  logic                       cf_in,
  output logic                       keep_dst,
  output logic [XLEN-1:0]            bmask,
  output logic [XLEN-1:0]            nxt_res,
  output logic                       nxt_cf
);
  logic [XLEN-1:0] sel_res;

  always_comb begin
    keep_dst = (op == OP_RSV) || (is_rotate(op) && amt_zero);
    bmask    = lane_mask(size);
    sel_res  = lane_res[size];
    nxt_res  = keep_dst ? dst_old : ((dst_old & ~bmask) | (sel_res & bmask));
    nxt_cf   = (keep_dst || amt_zero) ? cf_in : lane_cf[size];
  end
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
  import shrot_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [2:0]  op,
  input  logic [1:0]  size,
  input  logic [63:0] src,
  input  logic [5:0]  cnt,
  input  logic        cf_in,
  input  logic [63:0] dst_old,
  output logic        out_valid,
  output logic [63:0] result,
  output logic        cf_out
);
  shop_e                      op_e;
  logic [CNTW-1:0]            amt;
  logic                       amt_zero;
  logic [NSIZE-1:0][XLEN-1:0] lane_res;
  logic [NSIZE-1:0]           lane_cf;
  logic                       keep_dst;
  logic [XLEN-1:0]            bmask;
  logic [XLEN-1:0]            nxt_res;
  logic                       nxt_cf;
  logic [5:0]                 msb_idx;

  assign op_e    = shop_e'(op);
  assign msb_idx = 6'(op_width(size) - 1);

  shrot_count u_count (
    .size     (size),
    .cnt      (cnt),
    .amt      (amt),
    .amt_zero (amt_zero)
  );

  for (genvar g = 0; g < NSIZE; g++) begin : g_lane
    localparam int LW_G = 8 << g;
    logic [LW_G-1:0] res_g;
    logic            cf_g;
    shrot_lane #(.W(LW_G)) u_lane (
      .op     (op_e),
      .amt    (amt),
      .src    (src[LW_G-1:0]),
      .cf_in  (cf_in),
      .res    (res_g),
      .cf_out (cf_g)
    );
    assign lane_res[g] = XLEN'(res_g);
    assign lane_cf[g]  = cf_g;
  end

  shrot_merge u_merge (
    .op       (op_e),
    .size     (size),
    .amt_zero (amt_zero),
    .lane_res (lane_res),
    .lane_cf  (lane_cf),
    .dst_old  (dst_old),
    .cf_in    (cf_in),
    .keep_dst (keep_dst),
    .bmask    (bmask),
    .nxt_res  (nxt_res),
    .nxt_cf   (nxt_cf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      cf_out    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= nxt_res;
        cf_out <= nxt_cf;
      end
    end
  end

  // R1
  valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R1
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(cf_out) && !out_valid));
  // R12
  upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ((result & ~$past(bmask)) == ($past(dst_old) & ~$past(bmask))));
  // R10
  rot_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_rotate(op_e) && amt_zero) |=>
      (result == $past(dst_old) && cf_out == $past(cf_in)));
  // R11
  shift_zero_cf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && amt_zero) |=> (cf_out == $past(cf_in)));
  // R4
  shr_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_e == OP_SHR && !amt_zero) |=> (result[$past(msb_idx)] == 1'b0));
  // R5
  sar_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_e == OP_SAR) |=> (result[$past(msb_idx)] == $past(src[msb_idx])));
  // R13
  rsv_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_e == OP_RSV) |=>
      (result == $past(dst_old) && cf_out == $past(cf_in)));
endmodule

// File: tb/tb_shrot_unit.sv
module tb_shrot_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  op = '0;
  logic [1:0]  size = '0;
  logic [63:0] src = '0;
  logic [5:0]  cnt = '0;
  logic        cf_in = 1'b0;
  logic [63:0] dst_old = '0;
  logic        out_valid;
  logic [63:0] result;
  logic        cf_out;

  int n_checks = 0;
  int n_errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  shrot_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .size(size),
    .src(src), .cnt(cnt), .cf_in(cf_in), .dst_old(dst_old),
    .out_valid(out_valid), .result(result), .cf_out(cf_out)
  );

  // bit-serial reference: one single-bit step per count
  function automatic logic [64:0] ref_model(logic [2:0] o, logic [1:0] sz, logic [63:0] s,
                                            logic [5:0] c, logic cf, logic [63:0] d);
    int w = 8 << sz;
    int n = (sz == 2'd3) ? int'(c) : int'(c & 6'd31);
    logic [63:0] m = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    logic [63:0] v = s & m;
    logic cy = cf;
    logic b;
    if (o == 3'd7) return {cf, d};
    if (n == 0) begin
      if (o >= 3'd3) return {cf, d};
      return {cf, (d & ~m) | v};
    end
    for (int i = 0; i < n; i++) begin
      case (o)
        3'd0: begin cy = v[w-1]; v = (v << 1) & m; end
        3'd1: begin cy = v[0]; v = v >> 1; end
        3'd2: begin cy = v[0]; v = (v >> 1) | (64'(v[w-1]) << (w - 1)); end
        3'd3: begin b = v[w-1]; v = ((v << 1) | 64'(b)) & m; cy = b; end
        3'd4: begin b = v[0]; v = (v >> 1) | (64'(b) << (w - 1)); cy = b; end
        3'd5: begin b = v[w-1]; v = ((v << 1) | 64'(cy)) & m; cy = b; end
        default: begin b = v[0]; v = (v >> 1) | (64'(cy) << (w - 1)); cy = b; end
      endcase
    end
    return {cy, (d & ~m) | (v & m)};
  endfunction

  task automatic run_exp(input logic [2:0] o, input logic [1:0] sz, input logic [63:0] s,
                         input logic [5:0] c, input logic cf, input logic [63:0] d,
                         input logic [63:0] exp_res, input logic exp_cf, input string tag);
    @(negedge clk);
    op = o; size = sz; src = s; cnt = c; cf_in = cf; dst_old = d; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    n_checks++;
    if (result !== exp_res || cf_out !== exp_cf || out_valid !== 1'b1) begin
      n_errors++;
      $display("FAIL %s op=%0d size=%0d cnt=%0d: got res=%h cf=%b v=%b, expected res=%h cf=%b v=1",
               tag, o, sz, c, result, cf_out, out_valid, exp_res, exp_cf);
    end
  endtask

  task automatic run(input logic [2:0] o, input logic [1:0] sz, input logic [63:0] s,
                     input logic [5:0] c, input logic cf, input logic [63:0] d, input string tag);
    logic [64:0] e = ref_model(o, sz, s, c, cf, d);
    run_exp(o, sz, s, c, cf, d, e[63:0], e[64], tag);
  endtask

  function automatic string tag_for(logic [2:0] o, logic [1:0] sz, logic [5:0] c);
    int w = 8 << sz;
    int n = (sz == 2'd3) ? int'(c) : int'(c & 6'd31);
    if (o == 3'd7) return "R13";
    if (n == 0) return (o >= 3'd3) ? "R10" : "R11";
    if (sz != 2'd3 && c[5]) return "R2";
    if ((o == 3'd5 || o == 3'd6) && n > w) return "R9";
    case (o)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3, 3'd4: return "R6";
      3'd5: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: run did not complete, got hang, expected finish");
    finish_run();
  end

  initial begin
    logic [63:0] hold_res;
    logic        hold_cf;
    void'($urandom(32'd20240611));

    // R1 reset state
    @(negedge clk);
    n_checks++;
    if (out_valid !== 1'b0 || result !== 64'd0 || cf_out !== 1'b0) begin
      n_errors++;
      $display("FAIL R1 reset: got v=%b res=%h cf=%b, expected 0 0 0", out_valid, result, cf_out);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // directed corner cases with hand-derived values
    run_exp(3'd5, 2'd0, 64'h81, 6'd1, 1'b1, 64'hAAAA_AAAA_AAAA_AAAA,
            64'hAAAA_AAAA_AAAA_AA03, 1'b1, "R7");
    run_exp(3'd6, 2'd0, 64'h80, 6'd1, 1'b1, 64'h0, 64'hC0, 1'b0, "R8");
    run_exp(3'd2, 2'd1, 64'h8000, 6'd4, 1'b0, 64'h0, 64'hF800, 1'b0, "R5");
    run_exp(3'd5, 2'd0, 64'h5A, 6'd9, 1'b1, 64'h0, 64'h5A, 1'b1, "R9");
    run_exp(3'd1, 2'd0, 64'hFF, 6'd37, 1'b0, 64'h1234_5678_9ABC_DE00, 64'h1234_5678_9ABC_DE07, 1'b1, "R2");
    run_exp(3'd0, 2'd2, 64'hFFFF_FFFF_0000_0001, 6'd31, 1'b0, 64'hCAFE_0000_0000_0000,
            64'hCAFE_0000_8000_0000, 1'b0, "R12");
    run_exp(3'd4, 2'd3, 64'h1, 6'd0, 1'b1, 64'h1111, 64'h1111, 1'b1, "R10");
    run_exp(3'd7, 2'd1, 64'hFFFF, 6'd3, 1'b1, 64'h4242, 64'h4242, 1'b1, "R13");

    // R1 hold: inputs change without a request
    hold_res = result;
    hold_cf  = cf_out;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      src = rnd64(); dst_old = rnd64(); cnt = 6'(k + 1); cf_in = ~cf_in;
      n_checks++;
      if (result !== hold_res || cf_out !== hold_cf || out_valid !== 1'b0) begin
        n_errors++;
        $display("FAIL R1 hold: got res=%h cf=%b v=%b, expected res=%h cf=%b v=0",
                 result, cf_out, out_valid, hold_res, hold_cf);
      end
    end

    // full sweep of counts at every size and operation
    for (int o = 0; o < 8; o++)
      for (int sz = 0; sz < 4; sz++)
        for (int c = 0; c < 64; c++)
          run(3'(o), 2'(sz), rnd64(), 6'(c), 1'($urandom()), rnd64(),
              tag_for(3'(o), 2'(sz), 6'(c)));

    // random mix
    for (int k = 0; k < 1500; k++) begin
      logic [2:0] ro = 3'($urandom());
      logic [1:0] rs = 2'($urandom());
      logic [5:0] rc = 6'($urandom());
      run(ro, rs, rnd64(), rc, 1'($urandom()), rnd64(), tag_for(ro, rs, rc));
    end

    finish_run();
  end
endmodule